// File: doc/BRIEF.md
# Thermal Warning Hysteresis Monitor

This block watches a digitized reading taken from a thermistor divider, where the reading is a fraction of the supply and a lower value means a hotter sensor. It turns that reading into two sticky warning flags. The first flag asks for more cooling. The second flag reports a critical over-temperature condition. Each flag has its own set level and its own clear level, so a reading that hovers near one level does not make the flag chatter.

The two windows are nested. The level that clears the critical flag is the same level that raises the cooling request. Because of this, the critical flag can never be high while the cooling request is low. The levels are fixed fractions of full scale, given as percentages in parameters. With the default 10-bit sample, a percentage maps to round(pct * 1024 / 100), which gives these levels:

- cooling request: set below 338 (33 %), clear above 399 (39 %)
- over-temperature: set below 287 (28 %), clear above 338 (33 %)

Samples arrive on a valid/ready input. The sink applies no back-pressure: `s_ready` is low only during reset and in the first cycle after it. A sample transfers on a rising clock edge where `s_valid` and `s_ready` are both high. Both flags are registered, and a transferred sample is reflected in them from the cycle after the transfer.

Top module: `therm_hyst_mon`

## Requirements
- R1: While `rst_n` is low (synchronous reset), `fan_req`, `over_temp` and `s_ready` are all driven low from the next clock edge on.
- R2: A transferred sample strictly below the cooling set level (338 by default) makes `fan_req` high in the cycle after the transfer.
- R3: A transferred sample strictly above the cooling clear level (399 by default) makes `fan_req` low in the cycle after the transfer.
- R4: A transferred sample strictly below the critical set level (287 by default) makes `over_temp` high in the cycle after the transfer.
- R5: A transferred sample strictly above the critical clear level (338 by default) makes `over_temp` low in the cycle after the transfer.
- R6: A transferred sample equal to a flag's set or clear level, or lying between those two levels, leaves that flag unchanged.
- R7: In a cycle without a transfer, both flags keep their values, whatever is on `s_data`.
- R8: `over_temp` is never high while `fan_req` is low.
- R9: `s_ready` is high in every cycle after the first cycle out of reset. The block never back-pressures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high together with s_valid |
| s_data | input | ADC_W (10) | Unsigned reading; a lower value means a hotter sensor |
| fan_req | output | 1 | Cooling request flag |
| over_temp | output | 1 | Critical over-temperature flag |

## Verification
The bench drives samples that sit exactly on each of the three levels and one code to either side of them. A comparator written as `<=` or `>=` instead of a strict comparison would then flip a flag on the boundary code. Because 338 is both the cooling set level and the critical clear level, a swapped or shared threshold shows up as a flag that moves at the wrong crossing. Between transfers, the bench parks extreme codes on `s_data` with `s_valid` low, so a design that samples without the strobe loses its state. The bench also makes full-range jumps from coldest to hottest and back in a single sample, so a design that moves only one step per sample, or only one flag per sample, would show the wrong flag values.

// File: rtl/therm_hyst_pkg.sv
package therm_hyst_pkg;

  // Number of hysteresis windows handled by the monitor.
  localparam int unsigned N_WIN = 2;

  // Index of each window inside the flag vector.
  localparam int unsigned WIN_FAN = 0;
  localparam int unsigned WIN_OT  = 1;

  // Percent-of-full-scale to code, rounded to nearest, full scale = 2**w.
  function automatic int unsigned pct_level(input int unsigned pct,
                                            input int unsigned w);
    return (pct * (32'd1 << w) + 32'd50) / 32'd100;
  endfunction

endpackage

// File: rtl/thm_accept.sv
module thm_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  output logic take
);
  logic rdy_q;

  // Ready rises one cycle after reset is released and then stays high.
  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign s_ready = rdy_q;
  assign take    = s_valid & rdy_q;
endmodule

// File: rtl/thm_hyst_cell.sv
module thm_hyst_cell #(
  parameter int unsigned W       = 10,
  parameter int unsigned SET_LVL = 338,
  parameter int unsigned CLR_LVL = 399
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] sample,
  output logic         flag
);
  localparam logic [W-1:0] SET_V = W'(SET_LVL);
  localparam logic [W-1:0] CLR_V = W'(CLR_LVL);

  logic flag_q;
  logic flag_d;

  // Lower reading = hotter: strictly below set raises, strictly above clear drops.
  always_comb begin
    flag_d = flag_q;
    if (sample < SET_V)      flag_d = 1'b1;
    else if (sample > CLR_V) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (take) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/therm_hyst_mon.sv
module therm_hyst_mon
  import therm_hyst_pkg::*;
#(
  parameter int unsigned ADC_W       = 10,
  parameter int unsigned FAN_SET_PCT = 33,
  parameter int unsigned FAN_CLR_PCT = 39,
  parameter int unsigned OT_SET_PCT  = 28,
  parameter int unsigned OT_CLR_PCT  = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [ADC_W-1:0] s_data,
  output logic             fan_req,
  output logic             over_temp
);
  localparam int unsigned FAN_SET = pct_level(FAN_SET_PCT, ADC_W);
  localparam int unsigned FAN_CLR = pct_level(FAN_CLR_PCT, ADC_W);
  localparam int unsigned OT_SET  = pct_level(OT_SET_PCT,  ADC_W);
  localparam int unsigned OT_CLR  = pct_level(OT_CLR_PCT,  ADC_W);

  localparam int unsigned SET_TAB [N_WIN] = '{FAN_SET, OT_SET};
  localparam int unsigned CLR_TAB [N_WIN] = '{FAN_CLR, OT_CLR};

  logic             take;
  logic [N_WIN-1:0] flags;

  thm_accept u_accept (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .take    (take)
  );

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    thm_hyst_cell #(
      .W       (ADC_W),
      .SET_LVL (SET_TAB[g]),
      .CLR_LVL (CLR_TAB[g])
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .sample (s_data),
      .flag   (flags[g])
    );
  end

  assign fan_req   = flags[WIN_FAN];
  assign over_temp = flags[WIN_OT];
endmodule

// File: rtl/therm_hyst_mon_chk.sv
module therm_hyst_mon_chk
  import therm_hyst_pkg::*;
#(
  parameter int unsigned ADC_W       = 10,
  parameter int unsigned FAN_SET_PCT = 33,
  parameter int unsigned FAN_CLR_PCT = 39,
  parameter int unsigned OT_SET_PCT  = 28,
  parameter int unsigned OT_CLR_PCT  = 33
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic [ADC_W-1:0] s_data,
  input logic             fan_req,
  input logic             over_temp
);
  localparam logic [ADC_W-1:0] FS = ADC_W'(pct_level(FAN_SET_PCT, ADC_W));
  localparam logic [ADC_W-1:0] FC = ADC_W'(pct_level(FAN_CLR_PCT, ADC_W));
  localparam logic [ADC_W-1:0] OS = ADC_W'(pct_level(OT_SET_PCT,  ADC_W));
  localparam logic [ADC_W-1:0] OC = ADC_W'(pct_level(OT_CLR_PCT,  ADC_W));

  logic xfer;
  assign xfer = s_valid & s_ready;

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> (!fan_req && !over_temp && !s_ready));

  assert_fan_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && s_data < FS) |=> fan_req);

  assert_fan_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && s_data > FC) |=> !fan_req);

  assert_ot_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && s_data < OS) |=> over_temp);

  assert_ot_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && s_data > OC) |=> !over_temp);

  assert_fan_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && s_data >= FS && s_data <= FC) |=> $stable(fan_req));

  assert_ot_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && s_data >= OS && s_data <= OC) |=> $stable(over_temp));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(fan_req) && $stable(over_temp)));

  assert_nested_R8: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |-> fan_req);

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> s_ready);
endmodule

bind therm_hyst_mon therm_hyst_mon_chk #(
  .ADC_W       (ADC_W),
  .FAN_SET_PCT (FAN_SET_PCT),
  .FAN_CLR_PCT (FAN_CLR_PCT),
  .OT_SET_PCT  (OT_SET_PCT),
  .OT_CLR_PCT  (OT_CLR_PCT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .s_data    (s_data),
  .fan_req   (fan_req),
  .over_temp (over_temp)
);

// File: tb/therm_hyst_mon_bench.sv
`timescale 1ns/1ps
module therm_hyst_mon_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic [9:0] s_data = '0;
  logic       s_ready;
  logic       fan_req;
  logic       over_temp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  therm_hyst_mon u_therm_hyst_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .fan_req   (fan_req),
    .over_temp (over_temp)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One transfer; on return the registered result is visible.
  task automatic send(input logic [9:0] v);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = v;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 fan_req", fan_req, 1'b0);
    chk("R1 over_temp", over_temp, 1'b0);
    chk("R1 s_ready", s_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 s_ready", s_ready, 1'b1);
  endtask

  task automatic t_fan_window();
    send(10'd500); chk("R3 fan cool", fan_req, 1'b0);
    send(10'd338); chk("R6 fan at set", fan_req, 1'b0);
    send(10'd337); chk("R2 fan set", fan_req, 1'b1);
    chk("R4 ot not yet", over_temp, 1'b0);
    send(10'd399); chk("R6 fan at clear", fan_req, 1'b1);
    send(10'd370); chk("R6 fan in band", fan_req, 1'b1);
    send(10'd400); chk("R3 fan clear", fan_req, 1'b0);
    chk("R9 ready", s_ready, 1'b1);
  endtask

  task automatic t_ot_window();
    send(10'd337); chk("R2 fan set", fan_req, 1'b1);
    send(10'd287); chk("R6 ot at set", over_temp, 1'b0);
    send(10'd286); chk("R4 ot set", over_temp, 1'b1);
    chk("R8 fan with ot", fan_req, 1'b1);
    send(10'd338); chk("R6 ot at clear", over_temp, 1'b1);
    send(10'd339); chk("R5 ot clear", over_temp, 1'b0);
    chk("R6 fan kept", fan_req, 1'b1);
    send(10'd1023); chk("R3 fan full cold", fan_req, 1'b0);
  endtask

  task automatic t_hold();
    send(10'd100);
    chk("R4 hot", over_temp, 1'b1);
    chk("R2 hot", fan_req, 1'b1);
    s_data = 10'd1023;
    repeat (5) @(negedge clk);
    chk("R7 fan held", fan_req, 1'b1);
    chk("R7 ot held", over_temp, 1'b1);
    send(10'd1023);
    chk("R3 jump cold", fan_req, 1'b0);
    chk("R5 jump cold", over_temp, 1'b0);
    s_data = 10'd0;
    repeat (5) @(negedge clk);
    chk("R7 fan held low", fan_req, 1'b0);
    chk("R7 ot held low", over_temp, 1'b0);
  endtask

  task automatic t_jump();
    send(10'd0);
    chk("R2 jump hot", fan_req, 1'b1);
    chk("R4 jump hot", over_temp, 1'b1);
    send(10'd350);
    chk("R5 ot drop", over_temp, 1'b0);
    chk("R6 fan band", fan_req, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 fan mid", fan_req, 1'b0);
    chk("R1 ot mid", over_temp, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fan_window();
    t_ot_window();
    t_hold();
    t_jump();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule